// File: doc/BRIEF.md
# TDM Diagnostic Loopback Selector

This block stands between a TDM serial transmitter/receiver pair and the external serial pins. A two-bit diagnostic mode chooses one of four routings. In normal operation every path passes straight through. In automatic echo, the received pin data is sent back out of the transmit pin one clock later, and the transmitter's own data stays off the line. In internal loopback, the transmitter output feeds the receiver and still drives the transmit pin. In isolated loopback, the transmitter output feeds the receiver while the pins stay quiet.

The mode is loaded by a one-cycle load strobe and comes out of reset as normal operation. In every mode other than normal, the external grant input is ignored and the transmitter sees a permanently asserted grant. A single clock serves both directions, because the non-normal modes assume that the receive and transmit clocks are identical. The asynchronous active-low reset is released synchronously inside the block.

Top module: `tdm_diag_path`

## Requirements
- R1: While reset is applied, and after it is released, the current mode reads 2'b00 (normal) until a load occurs.
- R2: In mode 2'b00, rx_data_o equals pin_rxd_i, pin_txd_o equals tx_data_i, pin_req_o equals tx_req_i and tx_grant_o equals pin_grant_i, all in the same cycle.
- R3: In mode 2'b01 (echo), rx_data_o equals pin_rxd_i in the same cycle, and pin_txd_o equals the value pin_rxd_i had at the previous rising clock edge. tx_data_i never reaches the pin.
- R4: In mode 2'b01, pin_req_o is held at 0.
- R5: In mode 2'b10 (internal loopback), rx_data_o and pin_txd_o both equal tx_data_i, and pin_req_o equals tx_req_i.
- R6: In mode 2'b11 (isolated loopback), rx_data_o equals tx_data_i, pin_txd_o is all ones (idle), and pin_req_o is 0.
- R7: In modes 2'b01, 2'b10 and 2'b11, tx_grant_o is 1 whatever the value of pin_grant_i.
- R8: When cfg_load is high at a rising edge, cfg_mode becomes the current mode, shown on mode_o from that edge on. When cfg_load is low, the mode holds, whatever cfg_mode carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bit clock for receive and transmit |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the mode |
| cfg_mode | input | 2 | Mode value: 00 normal, 01 echo, 10 loopback, 11 isolated |
| mode_o | output | 2 | Current mode |
| tx_data_i | input | DATA_W | Data from the transmitter |
| tx_req_i | input | 1 | Request from the transmitter |
| tx_grant_o | output | 1 | Grant presented to the transmitter |
| rx_data_o | output | DATA_W | Data presented to the receiver |
| pin_rxd_i | input | DATA_W | Receive data pin |
| pin_txd_o | output | DATA_W | Transmit data pin |
| pin_req_o | output | 1 | Request pin |
| pin_grant_i | input | 1 | Grant pin |

## Verification
Every routed output except the echoed transmit bit is combinational from the inputs and the current mode, so it is due in the same cycle as its stimulus. The echoed bit is due exactly one rising edge after pin_rxd_i was sampled, and a mode load shows on mode_o and on the routing from the edge that captures it. The bench drives inputs on the falling edge, compares all outputs 2 ns later against a behavioural model, and advances that model only at the rising edge, where it records the echoed bit and applies any load.

// File: rtl/tdm_diag_pkg.sv
package tdm_diag_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_ECHO    = 2'b01,
    MODE_LOOP    = 2'b10,
    MODE_ISOLATE = 2'b11
  } diag_mode_e;

  // Transmitter output is routed to the receiver in both loopback modes
  function automatic logic mode_loops_tx(input diag_mode_e m);
    return (m == MODE_LOOP) || (m == MODE_ISOLATE);
  endfunction

  // Grant pin is only honoured in normal operation
  function automatic logic mode_uses_grant(input diag_mode_e m);
    return (m == MODE_NORMAL);
  endfunction

  // Request pin follows the transmitter only when its data reaches the line
  function automatic logic mode_drives_req(input diag_mode_e m);
    return (m == MODE_NORMAL) || (m == MODE_LOOP);
  endfunction

endpackage

// File: rtl/tdm_diag_rst_sync.sv
module tdm_diag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tdm_diag_mode_reg.sv
module tdm_diag_mode_reg
  import tdm_diag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  diag_mode_e mode_in,
  output diag_mode_e mode_q,
  output diag_mode_e mode_next
);

  always_comb begin
    mode_next = mode_q;
    if (load) mode_next = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_next;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode_q == $past(mode_in)));  // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q));  // R8

endmodule

// File: rtl/tdm_diag_echo_reg.sv
module tdm_diag_echo_reg #(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_next;
  end

endmodule

// File: rtl/tdm_diag_route.sv
module tdm_diag_route
  import tdm_diag_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  diag_mode_e        mode,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_req,
  input  logic [DATA_W-1:0] rxd_pin,
  input  logic [DATA_W-1:0] echo_bit,
  input  logic              grant_pin,
  output logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] txd_pin,
  output logic              req_pin,
  output logic              tx_grant
);

  localparam logic [DATA_W-1:0] LINE_IDLE = '1;

  always_comb begin
    rx_data  = mode_loops_tx(mode) ? tx_data : rxd_pin;
    req_pin  = mode_drives_req(mode) ? tx_req : 1'b0;
    tx_grant = mode_uses_grant(mode) ? grant_pin : 1'b1;
    unique case (mode)
      MODE_NORMAL:  txd_pin = tx_data;
      MODE_ECHO:    txd_pin = echo_bit;
      MODE_LOOP:    txd_pin = tx_data;
      MODE_ISOLATE: txd_pin = LINE_IDLE;
      default:      txd_pin = LINE_IDLE;
    endcase
  end

  AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ISOLATE) |-> ((txd_pin == LINE_IDLE) && !req_pin));  // R6
  AST_ECHO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ECHO) |-> !req_pin);  // R4
  AST_GRANT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_NORMAL) |-> tx_grant);  // R7
  AST_LOOP_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOOP) |-> ((rx_data == tx_data) && (txd_pin == tx_data)));  // R5

endmodule

// File: rtl/tdm_diag_path.sv
module tdm_diag_path
  import tdm_diag_pkg::*;
#(
  parameter int DATA_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  output logic [1:0]        mode_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_req_i,
  output logic              tx_grant_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic [DATA_W-1:0] pin_rxd_i,
  output logic [DATA_W-1:0] pin_txd_o,
  output logic              pin_req_o,
  input  logic              pin_grant_i
);

  logic       rst_n_int;
  diag_mode_e mode_q;
  diag_mode_e mode_next;
  logic       echo_en;
  logic [DATA_W-1:0] echo_q;

  tdm_diag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tdm_diag_mode_reg u_mode_reg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (cfg_load),
    .mode_in   (diag_mode_e'(cfg_mode)),
    .mode_q    (mode_q),
    .mode_next (mode_next)
  );

  // Capture only when echo is, or is about to be, the active mode
  assign echo_en = (mode_next == MODE_ECHO);

  tdm_diag_echo_reg #(.DATA_W(DATA_W)) u_echo_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (echo_en),
    .d     (pin_rxd_i),
    .q     (echo_q)
  );

  tdm_diag_route #(.DATA_W(DATA_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mode      (mode_q),
    .tx_data   (tx_data_i),
    .tx_req    (tx_req_i),
    .rxd_pin   (pin_rxd_i),
    .echo_bit  (echo_q),
    .grant_pin (pin_grant_i),
    .rx_data   (rx_data_o),
    .txd_pin   (pin_txd_o),
    .req_pin   (pin_req_o),
    .tx_grant  (tx_grant_o)
  );

  assign mode_o = mode_q;

  AST_ECHO_DELAY: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((mode_o == 2'b01) && ($past(mode_o) == 2'b01)) |-> (pin_txd_o == $past(pin_rxd_i)));  // R3
  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode_o == 2'b00) |-> ((pin_txd_o == tx_data_i) && (rx_data_o == pin_rxd_i)
                           && (tx_grant_o == pin_grant_i) && (pin_req_o == tx_req_i)));  // R2

  always_comb begin
    if (!rst_n) AST_RESET_MODE: assert (mode_o == 2'b00);  // R1
  end

endmodule

// File: tb/tdm_diag_path_bench.sv
`timescale 1ns/1ps
module tdm_diag_path_bench;

  localparam int W = 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_load;
  logic [1:0]   cfg_mode;
  logic [1:0]   mode_o;
  logic [W-1:0] tx_data_i;
  logic         tx_req_i;
  logic         tx_grant_o;
  logic [W-1:0] rx_data_o;
  logic [W-1:0] pin_rxd_i;
  logic [W-1:0] pin_txd_o;
  logic         pin_req_o;
  logic         pin_grant_i;

  int checks = 0;
  int fails  = 0;
  int m_mode;
  int m_echo;
  bit done = 0;

  always #4 clk = ~clk;

  tdm_diag_path #(.DATA_W(W)) u_tdm_diag_path (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode), .mode_o(mode_o),
    .tx_data_i(tx_data_i), .tx_req_i(tx_req_i), .tx_grant_o(tx_grant_o),
    .rx_data_o(rx_data_o), .pin_rxd_i(pin_rxd_i), .pin_txd_o(pin_txd_o),
    .pin_req_o(pin_req_o), .pin_grant_i(pin_grant_i)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (mode %0d)", req, what, act, exp, m_mode);
    end
  endtask

  task automatic compare_all();
    string tag;
    int exp_rx, exp_txd, exp_req, exp_gnt;
    case (m_mode)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R5";
      default: tag = "R6";
    endcase
    exp_rx  = (m_mode >= 2) ? int'(tx_data_i) : int'(pin_rxd_i);
    if (m_mode == 1)      exp_txd = m_echo;
    else if (m_mode == 3) exp_txd = (1 << W) - 1;
    else                  exp_txd = int'(tx_data_i);
    exp_req = (m_mode == 0 || m_mode == 2) ? int'(tx_req_i) : 0;
    exp_gnt = (m_mode == 0) ? int'(pin_grant_i) : 1;
    chk("R8", "mode_o", int'(mode_o), m_mode);
    chk(tag, "rx_data_o", int'(rx_data_o), exp_rx);
    chk(tag, "pin_txd_o", int'(pin_txd_o), exp_txd);
    chk((m_mode == 1) ? "R4" : tag, "pin_req_o", int'(pin_req_o), exp_req);
    chk((m_mode == 0) ? "R2" : "R7", "tx_grant_o", int'(tx_grant_o), exp_gnt);
  endtask

  task automatic drive_random(input bit allow_load);
    tx_data_i   = W'($urandom);
    tx_req_i    = 1'($urandom);
    pin_rxd_i   = W'($urandom);
    pin_grant_i = 1'($urandom);
    cfg_mode    = 2'($urandom);
    cfg_load    = allow_load && (($urandom % 8) == 0);
  endtask

  task automatic step(input bit allow_load);
    @(negedge clk);
    drive_random(allow_load);
    #2;
    compare_all();
    @(posedge clk);
    m_echo = int'(pin_rxd_i);
    if (cfg_load) m_mode = int'(cfg_mode);
  endtask

  task automatic load_mode(input int m);
    @(negedge clk);
    drive_random(1'b0);
    cfg_mode = 2'(m);
    cfg_load = 1'b1;
    #2;
    compare_all();
    @(posedge clk);
    m_echo = int'(pin_rxd_i);
    m_mode = m;
  endtask

  initial begin
    rst_n = 1'b0;
    m_mode = 0;
    m_echo = (1 << W) - 1;
    drive_random(1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "mode_o in reset", int'(mode_o), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0);
    chk("R1", "mode_o after release", int'(mode_o), 0);
    // directed walk through every mode, with long holds (R8 hold)
    load_mode(1); repeat (20) step(1'b0);
    load_mode(2); repeat (20) step(1'b0);
    load_mode(3); repeat (20) step(1'b0);
    load_mode(1); repeat (20) step(1'b0);
    load_mode(0); repeat (20) step(1'b0);
    load_mode(3); load_mode(1); repeat (10) step(1'b0);
    // random loads and traffic
    repeat (1500) step(1'b1);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule